// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block holds a 16-bit up-counter that advances on an enable tick, and a 16-bit compare register that is checked against the counter all the time. The counter first equalling the compare value produces a match event. A 4-bit mode field selects what the event does. It can set or clear an output latch that drives a pin. It can raise only the compare interrupt flag and leave the pin alone. It can also act as a period trigger: the counter is cleared and a one-cycle start request goes to an analog-to-digital converter.

Software writes the compare value, the mode and the two interrupt flags through simple write-enable ports. The pin has a direction input, and the block drives the pin only when that input selects output. Because trigger mode clears the counter without touching the overflow flag, the compare register works as a programmable timer period.

Top module: `cmpEventTimer`

## Requirements
- R1: The counter resets to 0. It increments by one on each clock edge with `tickEn` high and holds otherwise. It wraps from 16'hFFFF to 0, and the edge that wraps it sets `ovfFlag`.
- R2: When the counter newly equals the compare value in an active mode (4'b1000 to 4'b1011), `cmpFlag` is set on the next clock edge. While the counter stays at that value, the event is not repeated.
- R3: A match event in mode 4'b1000 sets the output latch (`pinOut`) to 1. In mode 4'b1001 it clears the latch to 0.
- R4: A match event in mode 4'b1010 sets `cmpFlag` and leaves `pinOut` unchanged.
- R5: A match event in mode 4'b1011 clears the counter to 0 on the same edge that sets `cmpFlag`. The clear takes priority over a tick in that cycle, and `ovfFlag` is not set.
- R6: In mode 4'b1011, `convStart` is high for exactly one cycle, which is the cycle in which the counter first reads 0 after the clear. The pulse is produced only when `adcEnable` was high when the event was taken.
- R7: Writing 4'b0000 to the mode field forces the output latch to 0 on that edge. This takes priority over a match event.
- R8: `pinOe` is the inverse of `pinDir`, where `pinDir` = 1 means input and high impedance. `pinOut` always carries the latch value.
- R9: In any mode outside 4'b1000 to 4'b1011, a match has no effect: `cmpFlag`, the latch and the counter are untouched.
- R10: With `flagWe` high, `flagIn[1]` loads `cmpFlag` and `flagIn[0]` loads `ovfFlag`. A hardware set in the same cycle wins.
- R11: After reset the compare value and mode are 0, and `pinOut`, both flags and `convStart` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| tickEn | input | 1 | Counter advance enable |
| cmpWe | input | 1 | Compare value write strobe |
| cmpIn | input | 16 | Compare value write data |
| modeWe | input | 1 | Mode write strobe |
| modeIn | input | 4 | Mode write data |
| flagWe | input | 1 | Flag write strobe |
| flagIn | input | 2 | Flag write data: bit 1 compare, bit 0 overflow |
| adcEnable | input | 1 | Converter enabled, gates the start request |
| pinDir | input | 1 | Pin direction, 1 = input (high impedance) |
| cntOut | output | 16 | Current counter value |
| cmpFlag | output | 1 | Compare interrupt flag |
| ovfFlag | output | 1 | Counter overflow interrupt flag |
| convStart | output | 1 | One-cycle start-conversion request |
| pinOut | output | 1 | Compare output latch |
| pinOe | output | 1 | Pin output enable |

## Verification
The assertions assume that software does not write the flags in the cycle it depends on for a rise. The overflow and compare flag properties therefore exclude any cycle after a `flagWe` write. They also assume that the mode is not rewritten in the cycle after a software-interrupt-mode match.

The stimulus changes registers only while the counter is parked away from the compare value. The counter is walked onto the compare value with `tickEn`, and no compare value of 0 is used in trigger mode. This keeps every match a single clean rising edge.

// File: rtl/cmpEventPkg.sv
package cmpEventPkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_OFF  = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_SET  = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_CLR  = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_SWI  = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_TRIG = 4'b1011;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
  } ctlStrobe_t;
endpackage

// File: rtl/cmpDatapath.sv
module cmpDatapath
  import cmpEventPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             cmpWe,
  input  logic [CNT_W-1:0] cmpIn,
  input  ctlStrobe_t       strobe,
  output logic [CNT_W-1:0] cntQ,
  output logic             matchEdge,
  output logic             wrapPulse
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cmpQ;
  logic             matchNow;
  logic             matchPrev;

  assign matchNow  = (cntQ == cmpQ);
  assign matchEdge = matchNow & ~matchPrev;
  assign wrapPulse = tickEn & (&cntQ) & ~strobe.clrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ      <= '0;
      cmpQ      <= '0;
      matchPrev <= 1'b1;
    end else begin
      matchPrev <= matchNow;
      if (cmpWe) cmpQ <= cmpIn;
      if (strobe.clrCnt)  cntQ <= '0;
      else if (tickEn)    cntQ <= cntQ + CNT_ONE;
    end
  end
endmodule

// File: rtl/cmpControl.sv
module cmpControl
  import cmpEventPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              flagWe,
  input  logic [1:0]        flagIn,
  input  logic              adcEnable,
  input  logic              matchEdge,
  input  logic              wrapPulse,
  output ctlStrobe_t        strobe,
  output logic [MODE_W-1:0] modeQ,
  output logic              pinLatch,
  output logic              cmpFlag,
  output logic              ovfFlag,
  output logic              convStart
);
  logic modeActive;
  logic evTaken;
  logic zeroWrite;

  assign modeActive    = (modeQ[MODE_W-1 -: 2] == 2'b10);
  assign evTaken       = matchEdge & modeActive;
  assign zeroWrite     = modeWe & (modeIn == MODE_OFF);
  assign strobe.clrCnt = evTaken & (modeQ == MODE_TRIG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_OFF;
      pinLatch  <= 1'b0;
      cmpFlag   <= 1'b0;
      ovfFlag   <= 1'b0;
      convStart <= 1'b0;
    end else begin
      if (modeWe) modeQ <= modeIn;
      if (zeroWrite)                            pinLatch <= 1'b0;
      else if (evTaken && modeQ == MODE_SET)    pinLatch <= 1'b1;
      else if (evTaken && modeQ == MODE_CLR)    pinLatch <= 1'b0;
      cmpFlag   <= evTaken   | (flagWe ? flagIn[1] : cmpFlag);
      ovfFlag   <= wrapPulse | (flagWe ? flagIn[0] : ovfFlag);
      convStart <= strobe.clrCnt & adcEnable;
    end
  end
endmodule

// File: rtl/cmpEventTimer.sv
module cmpEventTimer
  import cmpEventPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             cmpWe,
  input  logic [CNT_W-1:0] cmpIn,
  input  logic             modeWe,
  input  logic [3:0]       modeIn,
  input  logic             flagWe,
  input  logic [1:0]       flagIn,
  input  logic             adcEnable,
  input  logic             pinDir,
  output logic [CNT_W-1:0] cntOut,
  output logic             cmpFlag,
  output logic             ovfFlag,
  output logic             convStart,
  output logic             pinOut,
  output logic             pinOe
);
  ctlStrobe_t        strobe;
  logic              matchEdge;
  logic              wrapPulse;
  logic [MODE_W-1:0] modeQ;
  logic              pinLatch;

  cmpDatapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmpWe(cmpWe), .cmpIn(cmpIn),
    .strobe(strobe), .cntQ(cntOut), .matchEdge(matchEdge), .wrapPulse(wrapPulse)
  );

  cmpControl uCtl (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeIn(modeIn),
    .flagWe(flagWe), .flagIn(flagIn), .adcEnable(adcEnable),
    .matchEdge(matchEdge), .wrapPulse(wrapPulse), .strobe(strobe),
    .modeQ(modeQ), .pinLatch(pinLatch), .cmpFlag(cmpFlag),
    .ovfFlag(ovfFlag), .convStart(convStart)
  );

  assign pinOut = pinLatch;
  assign pinOe  = ~pinDir;
endmodule

// File: rtl/cmpEventTimerChk.sv
module cmpEventTimerChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             flagWe,
  input logic             modeWe,
  input logic [3:0]       modeIn,
  input logic [3:0]       modeQ,
  input logic             adcEnable,
  input logic [CNT_W-1:0] cntOut,
  input logic             cmpFlag,
  input logic             ovfFlag,
  input logic             convStart,
  input logic             pinOut
);
  // R1: overflow rises only from a tick at the all-ones count
  p_ovf_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ovfFlag) && !$past(flagWe)) |-> ($past(cntOut) == {CNT_W{1'b1}} && $past(tickEn)));

  // R2: compare flag rises only in an active mode
  p_flag_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cmpFlag) && !$past(flagWe)) |-> ($past(modeQ[3:2]) == 2'b10));

  // R4: software-interrupt mode leaves the pin alone
  p_swi_pin_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeQ) == 4'b1010 && !$past(modeWe)) |-> $stable(pinOut));

  // R5: start request coincides with a cleared counter
  p_trig_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (cntOut == '0));

  // R6: single-cycle pulse, gated by converter enable
  p_conv_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  p_conv_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStart) |-> $past(adcEnable));

  // R7: writing mode zero forces the latch low
  p_zero_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeWe && modeIn == 4'b0000) |=> !pinOut);
endmodule

bind cmpEventTimer cmpEventTimerChk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .flagWe(flagWe), .modeWe(modeWe),
  .modeIn(modeIn), .modeQ(modeQ), .adcEnable(adcEnable), .cntOut(cntOut),
  .cmpFlag(cmpFlag), .ovfFlag(ovfFlag), .convStart(convStart), .pinOut(pinOut)
);

// File: tb/cmpEventTimer_test.sv
`timescale 1ns/1ps
module cmpEventTimer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        cmpWe = 1'b0;
  logic [15:0] cmpIn = '0;
  logic        modeWe = 1'b0;
  logic [3:0]  modeIn = '0;
  logic        flagWe = 1'b0;
  logic [1:0]  flagIn = '0;
  logic        adcEnable = 1'b0;
  logic        pinDir = 1'b0;
  logic [15:0] cntOut;
  logic        cmpFlag, ovfFlag, convStart, pinOut, pinOe;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cmpEventTimer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmpWe(cmpWe), .cmpIn(cmpIn),
    .modeWe(modeWe), .modeIn(modeIn), .flagWe(flagWe), .flagIn(flagIn),
    .adcEnable(adcEnable), .pinDir(pinDir), .cntOut(cntOut), .cmpFlag(cmpFlag),
    .ovfFlag(ovfFlag), .convStart(convStart), .pinOut(pinOut), .pinOe(pinOe)
  );

  // behavioural reference model
  int mCnt, mCmp, mMode, mLatch, mCmpF, mOvf, mConv, mPrev;
  always @(posedge clk) begin
    int ev;
    int hit;
    if (!rstN) begin
      mCnt = 0; mCmp = 0; mMode = 0; mLatch = 0;
      mCmpF = 0; mOvf = 0; mConv = 0; mPrev = 1;
    end else begin
      hit = (mCnt == mCmp) ? 1 : 0;
      ev  = (hit == 1 && mPrev == 0 && mMode >= 8 && mMode <= 11) ? 1 : 0;
      mPrev = hit;
      if (flagWe) begin mCmpF = flagIn[1]; mOvf = flagIn[0]; end
      if (ev == 1) mCmpF = 1;
      mConv = (ev == 1 && mMode == 11 && adcEnable) ? 1 : 0;
      if (modeWe && modeIn == 0) mLatch = 0;
      else if (ev == 1 && mMode == 8) mLatch = 1;
      else if (ev == 1 && mMode == 9) mLatch = 0;
      if (ev == 1 && mMode == 11) mCnt = 0;
      else if (tickEn) begin
        if (mCnt == 65535) begin mCnt = 0; mOvf = 1; end
        else mCnt = mCnt + 1;
      end
      if (cmpWe) mCmp = int'(cmpIn);
      if (modeWe) mMode = int'(modeIn);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rstN) begin
      chk("R1 counter", int'(cntOut), mCnt);
      chk("R1 ovfFlag", int'(ovfFlag), mOvf);
      chk("R2 cmpFlag", int'(cmpFlag), mCmpF);
      chk("R3 pinOut", int'(pinOut), mLatch);
      chk("R6 convStart", int'(convStart), mConv);
      chk("R8 pinOe", int'(pinOe), pinDir ? 0 : 1);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wrCmp(int v);
    cmpWe = 1'b1; cmpIn = 16'(v); step(); cmpWe = 1'b0;
  endtask

  task automatic wrMode(logic [3:0] m);
    modeWe = 1'b1; modeIn = m; step(); modeWe = 1'b0;
  endtask

  task automatic wrFlags(logic [1:0] f);
    flagWe = 1'b1; flagIn = f; step(); flagWe = 1'b0;
  endtask

  task automatic tickTo(int v);
    tickEn = 1'b1;
    forever begin
      @(negedge clk);
      if (int'(cntOut) == v) break;
    end
    #1 tickEn = 1'b0;
  endtask

  initial begin
    step(4);
    rstN = 1'b1;
    step();
    // R11 reset state
    chk("R11 counter", int'(cntOut), 0);
    chk("R11 flags", int'({cmpFlag, ovfFlag}), 0);
    chk("R11 pinOut", int'(pinOut), 0);
    chk("R11 convStart", int'(convStart), 0);

    // R3 set on match
    wrCmp(10); wrMode(4'b1000);
    tickTo(10); step();
    chk("R3 latch set", int'(pinOut), 1);
    chk("R2 flag set", int'(cmpFlag), 1);

    // R4 software interrupt leaves pin
    wrFlags(2'b00); wrMode(4'b1010); wrCmp(30);
    tickTo(30); step();
    chk("R4 flag", int'(cmpFlag), 1);
    chk("R4 pin held", int'(pinOut), 1);
    // R2 no repeat while held at match
    wrFlags(2'b00); step(5);
    chk("R2 no repeat", int'(cmpFlag), 0);

    // R3 clear on match
    wrMode(4'b1001); wrCmp(40);
    tickTo(40); step();
    chk("R3 latch clear", int'(pinOut), 0);

    // R7 zero mode write
    wrMode(4'b1000); wrCmp(50);
    tickTo(50); step();
    chk("R7 pre latch", int'(pinOut), 1);
    wrMode(4'b0000);
    chk("R7 latch forced low", int'(pinOut), 0);

    // R9 inactive mode ignores match
    wrFlags(2'b00); wrMode(4'b0100); wrCmp(60);
    tickTo(60); step(2);
    chk("R9 no flag", int'(cmpFlag), 0);
    chk("R9 counter held", int'(cntOut), 60);

    // R5 / R6 trigger with converter enabled
    adcEnable = 1'b1; wrMode(4'b1011); wrCmp(100);
    tickEn = 1'b1;
    forever begin @(negedge clk); if (int'(cntOut) == 100) break; end
    @(negedge clk);
    chk("R5 counter cleared", int'(cntOut), 0);
    chk("R5 no overflow", int'(ovfFlag), 0);
    chk("R6 pulse", int'(convStart), 1);
    @(negedge clk);
    chk("R6 pulse one cycle", int'(convStart), 0);
    chk("R5 counting resumes", int'(cntOut), 1);
    #1 adcEnable = 1'b0;
    forever begin @(negedge clk); if (int'(cntOut) == 100) break; end
    @(negedge clk);
    chk("R6 gated off", int'(convStart), 0);
    chk("R5 cleared again", int'(cntOut), 0);
    #1 tickEn = 1'b0;

    // R10 flag write
    wrFlags(2'b11);
    chk("R10 cmp flag", int'(cmpFlag), 1);
    chk("R10 ovf flag", int'(ovfFlag), 1);
    wrFlags(2'b00);
    chk("R10 cleared", int'({cmpFlag, ovfFlag}), 0);

    // R1 wrap
    wrMode(4'b0000);
    tickTo(65535);
    tickEn = 1'b1; step(); tickEn = 1'b0;
    chk("R1 wrap count", int'(cntOut), 0);
    chk("R1 wrap flag", int'(ovfFlag), 1);

    // R8 direction
    pinDir = 1'b1; step();
    chk("R8 hi-z", int'(pinOe), 0);
    pinDir = 1'b0; step();
    chk("R8 driven", int'(pinOe), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule